// File: doc/BRIEF.md
# Quasi-Bidirectional Dual I/O Port

This block gives a small controller core its two general-purpose I/O ports. The first port is 8 bits wide. The second port has seven real pins and one internal position, for 15 pad lines in all. Every pin is quasi-bidirectional. A weak pull-up holds it high. A strong pull-down, enabled by this block, pulls it low. The core writes a latch for each pin. A 0 in the latch turns the pull-down on. A 1 releases the pin so that an outside source can drive it and the core can read it as an input.

The second port also carries alternate functions. Six of its pins serve, in fixed positions, as serial receive, serial transmit, two external interrupt lines and two timer count inputs. Before pin levels reach the core or the alternate-function outputs, they pass through a synchroniser of configurable depth. Position 6 of the second port has no pin. It always reads back the analog comparator result, and writes to it are dropped. The two low pins of the first port also feed the comparator's inputs.

The core uses a simple bus. It writes a latch in one cycle. A read returns either the synchronised pin levels or, for a read-modify-write access, the latch contents.

Top module: `qbio_ports`

## Requirements
- R1: While `rst` is high, no pull-down is enabled on any pin, with no clock edge needed. A synchronous reset sets every latch bit to 1, so after reset a read-modify-write read (`rd_rmw`=1) of the first port returns 0xFF.
- R2: On the first port, `pa_pd_o[i]` is 1 exactly when latch bit i is 0. A write (`wr_en`=1, `wr_port`=0) takes effect on `pa_pd_o` from the next clock edge. On the second port the same rule holds for every pin except the transmit pin, which R6 covers.
- R3: A plain read (`rd_rmw`=0) returns the pin levels after `SYNC_STAGES` (default 2) clock edges of synchronisation. A pin whose latch is 1 and that is pulled low outside reads 0.
- R4: A read-modify-write read returns the latch contents, not the pin levels, even when an outside source pulls a released pin low.
- R5: Second-port position 6 has no pin. Both kinds of read return the synchronised comparator result `cmp_i` in bit 6, and a 1 or a 0 written to bit 6 has no effect.
- R6: The transmit pin (second-port bit 1) has its pull-down enabled when its latch bit is 0 or when `ser_tx_i` is 0.
- R7: After synchronisation, `ser_rx_o` follows second-port bit 0, `ext_int_o[0]` and `ext_int_o[1]` follow bits 2 and 3, and `tmr_cnt_o[0]` and `tmr_cnt_o[1]` follow bits 4 and 5, each `SYNC_STAGES` edges after the pin changes.
- R8: `cmp_pos_o` and `cmp_neg_o` carry the levels of first-port pins 0 and 1 without delay.
- R9: The second port's pad vectors are 7 bits wide. Index 0..5 maps to port bits 0..5, and index 6 maps to port bit 7.
- R10: `wr_port` selects the latch that is written (0 = first port, 1 = second port). The other port's latch stays unchanged. `rd_port` selects the port that is read in the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also releases all pins at once |
| wr_en | input | 1 | Latch write strobe |
| wr_port | input | 1 | Port written: 0 first, 1 second |
| wr_data | input | 8 | Latch write value |
| rd_port | input | 1 | Port read: 0 first, 1 second |
| rd_rmw | input | 1 | 1 returns latch contents, 0 returns synchronised pin levels |
| rd_data | output | 8 | Read result |
| pa_pin_i | input | 8 | First-port pad levels |
| pa_pd_o | output | 8 | First-port pull-down enables |
| pb_pin_i | input | 7 | Second-port pad levels (index 6 = port bit 7) |
| pb_pd_o | output | 7 | Second-port pull-down enables (index 6 = port bit 7) |
| cmp_i | input | 1 | Comparator result |
| cmp_pos_o | output | 1 | Comparator positive input (first-port pin 0) |
| cmp_neg_o | output | 1 | Comparator negative input (first-port pin 1) |
| ser_tx_i | input | 1 | Serial transmit output from the core |
| ser_rx_o | output | 1 | Synchronised serial receive input |
| ext_int_o | output | 2 | Synchronised external interrupt inputs |
| tmr_cnt_o | output | 2 | Synchronised timer count inputs |

## Verification
The assertions check on every cycle that reset releases all pins and that a first-port write shows up on the pull-downs at the next edge. They also check that a low transmit output always pulls its pin, that the alternate-function inputs and the comparator bit lag their sources by exactly two edges, and that a read-modify-write read right after a write returns the written byte. Only the bench scenarios can show the rest. These are the difference between plain and read-modify-write reads when outside sources pull released pins low, that writes to the missing position are dropped, the mapping of the 7-bit pad vectors, and that a write to one port leaves the other port alone.

// File: rtl/qbio_pkg.sv
package qbio_pkg;

    localparam int PORT_W  = 8;
    localparam int PB_PINS = PORT_W - 1;

    // Fixed positions on the second port
    localparam int RXD_BIT  = 0;
    localparam int TXD_BIT  = 1;
    localparam int INT0_BIT = 2;
    localparam int INT1_BIT = 3;
    localparam int T0_BIT   = 4;
    localparam int T1_BIT   = 5;
    localparam int CMP_BIT  = 6;

    // Comparator inputs on the first port
    localparam int CMP_POS_BIT = 0;
    localparam int CMP_NEG_BIT = 1;

    typedef logic [PORT_W-1:0]  port_word_t;
    typedef logic [PB_PINS-1:0] pb_pins_t;

    typedef enum logic {
        PORT_A = 1'b0,
        PORT_B = 1'b1
    } port_id_e;

    typedef struct packed {
        logic t1;
        logic t0;
        logic int1;
        logic int0;
        logic rxd;
    } alt_in_t;

    // Put the comparator bit into its position between the pins
    function automatic port_word_t pb_expand(input pb_pins_t pins, input logic cmp);
        port_word_t w;
        for (int i = 0; i < PORT_W; i++) begin
            if (i < CMP_BIT)       w[i] = pins[i];
            else if (i == CMP_BIT) w[i] = cmp;
            else                   w[i] = pins[i-1];
        end
        return w;
    endfunction

    // Take the comparator position out of a port word
    function automatic pb_pins_t pb_compress(input port_word_t w);
        pb_pins_t p;
        for (int i = 0; i < PB_PINS; i++) begin
            if (i < CMP_BIT) p[i] = w[i];
            else             p[i] = w[i+1];
        end
        return p;
    endfunction

endpackage

// File: rtl/qbio_sync.sv
module qbio_sync #(
    parameter int             W       = 8,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < STAGES; k++) stg[k] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/qbio_latch.sv
module qbio_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= '1;
        else if (we) q <= d;
    end
endmodule

// File: rtl/qbio_drive.sv
module qbio_drive
    import qbio_pkg::*;
(
    input  logic       rst,
    input  port_word_t latch_a,
    input  pb_pins_t   latch_b,
    input  logic       ser_tx,
    output port_word_t pa_pd,
    output pb_pins_t   pb_pd
);
    for (genvar i = 0; i < PORT_W; i++) begin : g_pa
        assign pa_pd[i] = ~rst & ~latch_a[i];
    end

    for (genvar j = 0; j < PB_PINS; j++) begin : g_pb
        if (j == TXD_BIT) begin : g_tx
            assign pb_pd[j] = ~rst & ~(latch_b[j] & ser_tx);
        end else begin : g_io
            assign pb_pd[j] = ~rst & ~latch_b[j];
        end
    end
endmodule

// File: rtl/qbio_rdmux.sv
module qbio_rdmux
    import qbio_pkg::*;
(
    input  logic       rd_port,
    input  logic       rd_rmw,
    input  port_word_t latch_a,
    input  port_word_t latch_b_word,
    input  port_word_t pins_a,
    input  port_word_t pins_b_word,
    output port_word_t rd_data
);
    always_comb begin
        unique case ({port_id_e'(rd_port), rd_rmw})
            {PORT_A, 1'b1}: rd_data = latch_a;
            {PORT_A, 1'b0}: rd_data = pins_a;
            {PORT_B, 1'b1}: rd_data = latch_b_word;
            default:        rd_data = pins_b_word;
        endcase
    end
endmodule

// File: rtl/qbio_ports.sv
module qbio_ports
    import qbio_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic         wr_port,
    input  logic [7:0]   wr_data,
    input  logic         rd_port,
    input  logic         rd_rmw,
    output logic [7:0]   rd_data,
    input  logic [7:0]   pa_pin_i,
    output logic [7:0]   pa_pd_o,
    input  logic [6:0]   pb_pin_i,
    output logic [6:0]   pb_pd_o,
    input  logic         cmp_i,
    output logic         cmp_pos_o,
    output logic         cmp_neg_o,
    input  logic         ser_tx_i,
    output logic         ser_rx_o,
    output logic [1:0]   ext_int_o,
    output logic [1:0]   tmr_cnt_o
);
    localparam int PBS_W = PB_PINS + 1;

    port_word_t latch_a;
    pb_pins_t   latch_b;
    port_word_t pins_a_s;
    logic [PBS_W-1:0] pb_cmp_s;
    pb_pins_t   pins_b_s;
    logic       cmp_s;
    alt_in_t    alt;

    logic we_a, we_b;
    assign we_a = wr_en & (port_id_e'(wr_port) == PORT_A);
    assign we_b = wr_en & (port_id_e'(wr_port) == PORT_B);

    qbio_latch #(.W(PORT_W)) u_latch_a (
        .clk(clk), .rst(rst), .we(we_a), .d(wr_data), .q(latch_a)
    );

    // The comparator position has no storage: writes to it are dropped
    qbio_latch #(.W(PB_PINS)) u_latch_b (
        .clk(clk), .rst(rst), .we(we_b), .d(pb_compress(wr_data)), .q(latch_b)
    );

    qbio_drive u_drive (
        .rst(rst), .latch_a(latch_a), .latch_b(latch_b), .ser_tx(ser_tx_i),
        .pa_pd(pa_pd_o), .pb_pd(pb_pd_o)
    );

    qbio_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync_a (
        .clk(clk), .rst(rst), .d(pa_pin_i), .q(pins_a_s)
    );

    qbio_sync #(.W(PBS_W), .STAGES(SYNC_STAGES)) u_sync_b (
        .clk(clk), .rst(rst), .d({cmp_i, pb_pin_i}), .q(pb_cmp_s)
    );

    assign pins_b_s = pb_cmp_s[PB_PINS-1:0];
    assign cmp_s    = pb_cmp_s[PB_PINS];

    assign alt.rxd  = pins_b_s[RXD_BIT];
    assign alt.int0 = pins_b_s[INT0_BIT];
    assign alt.int1 = pins_b_s[INT1_BIT];
    assign alt.t0   = pins_b_s[T0_BIT];
    assign alt.t1   = pins_b_s[T1_BIT];

    assign ser_rx_o  = alt.rxd;
    assign ext_int_o = {alt.int1, alt.int0};
    assign tmr_cnt_o = {alt.t1, alt.t0};

    assign cmp_pos_o = pa_pin_i[CMP_POS_BIT];
    assign cmp_neg_o = pa_pin_i[CMP_NEG_BIT];

    qbio_rdmux u_rdmux (
        .rd_port     (rd_port),
        .rd_rmw      (rd_rmw),
        .latch_a     (latch_a),
        .latch_b_word(pb_expand(latch_b, cmp_s)),
        .pins_a      (pins_a_s),
        .pins_b_word (pb_expand(pins_b_s, cmp_s)),
        .rd_data     (rd_data)
    );
endmodule

// File: rtl/qbio_ports_chk.sv
module qbio_ports_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic       wr_port,
    input logic [7:0] wr_data,
    input logic       rd_port,
    input logic       rd_rmw,
    input logic [7:0] rd_data,
    input logic [7:0] pa_pd_o,
    input logic [6:0] pb_pin_i,
    input logic [6:0] pb_pd_o,
    input logic       cmp_i,
    input logic       ser_tx_i,
    input logic       ser_rx_o,
    input logic [1:0] ext_int_o,
    input logic [1:0] tmr_cnt_o
);
    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)                 since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R1: reset releases every pin at once
    always_comb begin
        if (rst) begin
            a_r1_release_in_reset: assert (pa_pd_o == '0 && pb_pd_o == '0);
        end
    end

    // R2
    a_r2_write_drives_pd: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_port == 1'b0) |=> (pa_pd_o == ~$past(wr_data)));

    // R6
    a_r6_tx_low_pulls: assert property (@(posedge clk) disable iff (rst)
        !ser_tx_i |-> pb_pd_o[1]);

    // R4
    a_r4_rmw_returns_latch: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_port == 1'b0) ##1 (rd_rmw && rd_port == 1'b0 && !wr_en)
        |-> rd_data == $past(wr_data));

    // R7
    a_r7_alt_latency: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2) |->
        ({tmr_cnt_o, ext_int_o, ser_rx_o} ==
         $past({pb_pin_i[5], pb_pin_i[4], pb_pin_i[3], pb_pin_i[2], pb_pin_i[0]}, 2)));

    // R5
    a_r5_cmp_readback: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2 && rd_port == 1'b1) |-> rd_data[6] == $past(cmp_i, 2));
endmodule

bind qbio_ports qbio_ports_chk chk_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_port(wr_port), .wr_data(wr_data),
    .rd_port(rd_port), .rd_rmw(rd_rmw), .rd_data(rd_data), .pa_pd_o(pa_pd_o),
    .pb_pin_i(pb_pin_i), .pb_pd_o(pb_pd_o), .cmp_i(cmp_i), .ser_tx_i(ser_tx_i),
    .ser_rx_o(ser_rx_o), .ext_int_o(ext_int_o), .tmr_cnt_o(tmr_cnt_o)
);

// File: tb/qbio_ports_tb_top.sv
module qbio_ports_tb_top;
    localparam int CLK_PERIOD = 10;

    typedef enum int {K_RD, K_PDA, K_PDB, K_ALT, K_CMP} kind_e;
    typedef struct {
        kind_e      kind;
        logic [7:0] exp;
        string      tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, wr_port = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_port = 1'b0, rd_rmw = 1'b0;
    logic [7:0] rd_data;
    logic [7:0] pa_pin, pa_pd;
    logic [6:0] pb_pin, pb_pd;
    logic       cmp_in = 1'b0, cmp_pos, cmp_neg;
    logic       ser_tx = 1'b1, ser_rx;
    logic [1:0] ext_int, tmr_cnt;
    logic [7:0] ext_low_a = '0;
    logic [6:0] ext_low_b = '0;

    int total = 0;
    int bad   = 0;
    item_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    // pad model: weak pull-up, low when the block or an outside source pulls
    assign pa_pin = ~(pa_pd | ext_low_a);
    assign pb_pin = ~(pb_pd | ext_low_b);

    qbio_ports dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_port(wr_port), .wr_data(wr_data),
        .rd_port(rd_port), .rd_rmw(rd_rmw), .rd_data(rd_data),
        .pa_pin_i(pa_pin), .pa_pd_o(pa_pd), .pb_pin_i(pb_pin), .pb_pd_o(pb_pd),
        .cmp_i(cmp_in), .cmp_pos_o(cmp_pos), .cmp_neg_o(cmp_neg),
        .ser_tx_i(ser_tx), .ser_rx_o(ser_rx), .ext_int_o(ext_int), .tmr_cnt_o(tmr_cnt)
    );

    // monitor: pops expected items and compares them with the outputs
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it = q.pop_front();
                case (it.kind)
                    K_RD:    act = rd_data;
                    K_PDA:   act = pa_pd;
                    K_PDB:   act = {1'b0, pb_pd};
                    K_ALT:   act = {3'b0, tmr_cnt[1], tmr_cnt[0], ext_int[1], ext_int[0], ser_rx};
                    default: act = {6'b0, cmp_neg, cmp_pos};
                endcase
                total++;
                if (act !== it.exp) begin
                    bad++;
                    $display("FAIL %s: actual=%02h expected=%02h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic expect_out(input kind_e k, input logic [7:0] e, input string tag);
        item_t it;
        @(negedge clk);
        it.kind = k; it.exp = e; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic expect_rd(input logic port, input logic rmw, input logic [7:0] e,
                             input string tag);
        item_t it;
        @(negedge clk);
        rd_port = port; rd_rmw = rmw;
        it.kind = K_RD; it.exp = e; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic write_port(input logic port, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_port = port; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: pins released during reset, latches all ones after
        expect_out(K_PDA, 8'h00, "R1 pd A in reset");
        expect_out(K_PDB, 8'h00, "R1 pd B in reset");
        @(negedge clk); rst = 1'b0;
        settle();
        expect_rd(1'b0, 1'b1, 8'hFF, "R1 rmw A after reset");
        expect_rd(1'b1, 1'b1, 8'hBF, "R1 rmw B after reset, cmp 0");

        // R2, R4, R3: drive a pattern on port A
        write_port(1'b0, 8'h5A);
        expect_out(K_PDA, 8'hA5, "R2 pd A follows latch");
        expect_rd(1'b0, 1'b1, 8'h5A, "R4 rmw A latch");
        settle();
        expect_rd(1'b0, 1'b0, 8'h5A, "R3 plain A pins");
        expect_rd(1'b1, 1'b1, 8'hBF, "R10 port B untouched by A write");

        // R3/R4: released pins pulled low from outside
        write_port(1'b0, 8'hFF);
        @(negedge clk); ext_low_a = 8'h0F;
        settle();
        expect_rd(1'b0, 1'b0, 8'hF0, "R3 plain A outside low");
        expect_rd(1'b0, 1'b1, 8'hFF, "R4 rmw A ignores pins");
        expect_out(K_CMP, 8'h00, "R8 comparator inputs both low");
        @(negedge clk); ext_low_a = 8'h01;
        expect_out(K_CMP, 8'h02, "R8 pos low neg high");
        @(negedge clk); ext_low_a = 8'h00;

        // R5: comparator position
        @(negedge clk); cmp_in = 1'b1;
        write_port(1'b1, 8'h00);
        expect_out(K_PDB, 8'h7F, "R2 pd B all pins");
        settle();
        expect_rd(1'b1, 1'b1, 8'h40, "R5 rmw B bit6 is cmp");
        expect_rd(1'b1, 1'b0, 8'h40, "R5 plain B bit6 is cmp");
        write_port(1'b1, 8'hBF);
        expect_rd(1'b1, 1'b1, 8'hFF, "R5 write 0 to bit6 ignored");
        @(negedge clk); cmp_in = 1'b0;
        settle();
        expect_rd(1'b1, 1'b0, 8'hBF, "R5 plain B follows cmp 0");
        expect_rd(1'b0, 1'b1, 8'hFF, "R10 port A untouched by B write");

        // R6: transmit pin
        @(negedge clk); ser_tx = 1'b0;
        expect_out(K_PDB, 8'h02, "R6 tx low pulls pin");
        @(negedge clk); ser_tx = 1'b1;
        expect_out(K_PDB, 8'h00, "R6 tx high releases");
        write_port(1'b1, 8'hFD);
        expect_out(K_PDB, 8'h02, "R6 latch 0 pulls tx pin");
        write_port(1'b1, 8'hFF);

        // R7: alternate inputs and their latency
        settle();
        expect_out(K_ALT, 8'h1F, "R7 alt idle high");
        @(negedge clk); ext_low_b = 7'b0010101;
        expect_out(K_ALT, 8'h1F, "R7 alt not yet after one edge");
        expect_out(K_ALT, 8'h14, "R7 alt after two edges");
        @(negedge clk); ext_low_b = 7'b0101010;
        settle();
        expect_out(K_ALT, 8'h0B, "R7 alt second pattern");

        // R9: index 6 is port bit 7
        @(negedge clk); ext_low_b = 7'b1000000;
        settle();
        expect_rd(1'b1, 1'b0, 8'h3F, "R9 pad index 6 reads as bit 7");
        @(negedge clk); ext_low_b = '0;
        write_port(1'b1, 8'h7F);
        expect_out(K_PDB, 8'h40, "R9 bit 7 drives pad index 6");

        // R1 again: reset releases at once and restores ones
        write_port(1'b0, 8'h00);
        @(negedge clk); rst = 1'b1;
        #1;
        total++;
        if (pa_pd !== 8'h00) begin
            bad++;
            $display("FAIL R1 immediate release: actual=%02h expected=00", pa_pd);
        end
        @(negedge clk); rst = 1'b0;
        expect_rd(1'b0, 1'b1, 8'hFF, "R1 latch ones after second reset");

        @(negedge clk);
        @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule